// File: doc/BRIEF.md
# Volume-Scaled Serial DAC Sample Streamer

The block takes audio samples one at a time over a valid/ready handshake and plays each one out to a 12-bit serial DAC as a single 16-bit write. A per-sample width flag selects how the sample is read:

- **Wide sample:** 16-bit two's complement.
- **Narrow sample:** 8-bit unsigned.

Either form is first reduced to a 12-bit offset-binary code. The code is then multiplied by a 10-bit volume word and divided by 1024, which gives smooth attenuation in 1024 steps without any fractional arithmetic.

The serial write carries a fixed 4-bit command prefix on top and the scaled code below it. It is sent in SPI mode 0 under an active-low chip select. The serial clock comes from the system clock through a parameterized half-period divider.

The volume word is captured together with the sample, so moving the volume control mid-frame never corrupts a write already on the wire. The input is held not-ready for the whole frame and for a guard gap after it.

Top module: `vol_dac_streamer`

## Requirements
- R1: After a synchronous active-high reset, `s_ready` is 1, `dac_cs_n` is 1 and `dac_sclk` is 0.
- R2: When `s_wide` is 1, `s_data` is read as signed 16-bit. The code is `{~s_data[15], s_data[14:4]}`, i.e. the sign bit is inverted and the top 12 bits are kept.
- R3: When `s_wide` is 0, only `s_data[7:0]` is used and the code is `{s_data[7:0], 4'b0000}`. Bits `s_data[15:8]` have no effect on the frame.
- R4: The level sent is `(code * volume) >> 10`, with `volume` in 0..1023. A code of 4095 at volume 1023 gives 4091, and volume 0 gives 0.
- R5: Each frame is 16 bits, most significant bit first. Bits 15..12 are the fixed command `0011` and bits 11..0 are the scaled level.
- R6: SPI mode 0 is used. `dac_mosi` changes only while `dac_sclk` is low and is stable whenever `dac_sclk` is high. Each serial clock period is `2*HALF_DIV` system clocks.
- R7: `dac_cs_n` falls before the first rising `dac_sclk` edge of a frame. It stays low for exactly 16 rising edges and rises only after the last of them.
- R8: `s_ready` is 0 from the cycle after a sample is accepted until the frame and its guard gap have ended.
- R9: Between frames, `dac_cs_n` stays high for at least one full serial clock period (`2*HALF_DIV` system clocks).
- R10: `volume` is captured in the accepting cycle; changes to it during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Block can take a sample |
| s_wide | input | 1 | 1: 16-bit signed sample, 0: 8-bit unsigned in bits 7..0 |
| s_data | input | 16 | Sample value |
| volume | input | 10 | Attenuation factor, 0..1023 (unity is 1024) |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_mosi | output | 1 | Serial data, MSB first |
| dac_cs_n | output | 1 | Active-low frame select |

## Verification
A fault in the sign or nibble handling, or in the multiply-and-shift path, shows up in the captured serial word of the very frame that carries the faulty sample. The mismatch lies in the low 12 bits, while the `0011` prefix still arrives intact. A wrong half-phase counter shows within one frame in one of three ways: a bit count other than 16 under chip select, a data edge while the clock is high, or a guard gap shorter than one serial period. A volume register that follows the live input instead of the captured value shows as a frame level belonging to the later volume.

// File: rtl/vds_pkg.sv
package vds_pkg;
  localparam int SAMPLE_W = 16;
  localparam int CODE_W   = 12;
  localparam int VOL_W    = 10;
  localparam int CMD_W    = 4;
  localparam int FRAME_W  = CMD_W + CODE_W;
  localparam int PROD_W   = CODE_W + VOL_W;
  localparam logic [CMD_W-1:0] DAC_CMD = 4'b0011;

  // Offset-binary 12-bit code from either sample form.
  function automatic logic [CODE_W-1:0] to_code(input logic [SAMPLE_W-1:0] d,
                                                input logic wide);
    logic [SAMPLE_W-1:0] u;
    u = wide ? {~d[SAMPLE_W-1], d[SAMPLE_W-2:0]} : {d[7:0], 8'h00};
    return u[SAMPLE_W-1 -: CODE_W];
  endfunction

  // Fractional volume: multiply, then drop VOL_W fraction bits.
  function automatic logic [CODE_W-1:0] scale(input logic [CODE_W-1:0] c,
                                              input logic [VOL_W-1:0] v);
    logic [PROD_W-1:0] p;
    p = PROD_W'(c) * PROD_W'(v);
    return p[PROD_W-1 -: CODE_W];
  endfunction
endpackage

// File: rtl/vds_sample_conv.sv
module vds_sample_conv
  import vds_pkg::*;
(
  input  logic [SAMPLE_W-1:0] data,
  input  logic                wide,
  input  logic [VOL_W-1:0]    vol,
  output logic [FRAME_W-1:0]  frame
);
  logic [CODE_W-1:0] code;
  logic [CODE_W-1:0] level;

  always_comb begin
    code  = to_code(data, wide);
    level = scale(code, vol);
    frame = {DAC_CMD, level};
  end

  // R4: attenuation never raises the level above the unscaled code
  always_comb begin
    a_r4_no_gain: assert (level <= code);
  end
endmodule

// File: rtl/vds_half_tick.sv
module vds_half_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF_DIV + 1);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vds_frame_shifter.sv
module vds_frame_shifter #(
  parameter int FRAME_W  = 16,
  parameter int HALF_DIV = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] word,
  output logic               ready,
  output logic               sclk,
  output logic               mosi,
  output logic               cs_n
);
  // Half phases: 0..2F-1 clocking, 2F trailing low, 2F+1..2F+2 guard gap.
  localparam int LAST_PH = 2 * FRAME_W + 2;
  localparam int PH_W    = $clog2(LAST_PH + 1);

  logic               busy;
  logic [PH_W-1:0]    ph;
  logic [PH_W-1:0]    np;
  logic [FRAME_W-1:0] sreg;
  logic               tick;

  vds_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst(rst), .run(busy), .tick(tick)
  );

  assign ready = !busy;
  assign np    = ph + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ph   <= '0;
      sreg <= '0;
      sclk <= 1'b0;
      mosi <= 1'b0;
      cs_n <= 1'b1;
    end else if (load && !busy) begin
      busy <= 1'b1;
      ph   <= '0;
      sreg <= word;
      mosi <= word[FRAME_W-1];
      cs_n <= 1'b0;
      sclk <= 1'b0;
    end else if (busy && tick) begin
      if (ph == PH_W'(LAST_PH)) begin
        busy <= 1'b0;
      end else begin
        ph <= np;
        if (np < PH_W'(2 * FRAME_W)) begin
          sclk <= np[0];
          if (!np[0]) begin
            sreg <= sreg << 1;
            mosi <= sreg[FRAME_W-2];
          end
        end else if (np == PH_W'(2 * FRAME_W)) begin
          sclk <= 1'b0;
        end else begin
          cs_n <= 1'b1;
        end
      end
    end
  end

  // R6: data holds across the rising serial clock edge
  a_r6_mosi_stable_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(mosi));
  // R7: serial clock pulses only inside a frame
  a_r7_sclk_in_frame: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !cs_n);
  // R9: a rising chip select is followed by a gap, not a new frame
  a_r9_gap_after_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> (cs_n && !ready));
endmodule

// File: rtl/vol_dac_streamer.sv
module vol_dac_streamer
  import vds_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic                s_wide,
  input  logic [SAMPLE_W-1:0] s_data,
  input  logic [VOL_W-1:0]    volume,
  output logic                dac_sclk,
  output logic                dac_mosi,
  output logic                dac_cs_n
);
  logic               accept;
  logic [FRAME_W-1:0] frame;

  assign accept = s_valid && s_ready;

  vds_sample_conv u_conv (
    .data(s_data), .wide(s_wide), .vol(volume), .frame(frame)
  );

  vds_frame_shifter #(.FRAME_W(FRAME_W), .HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst(rst), .load(accept), .word(frame),
    .ready(s_ready), .sclk(dac_sclk), .mosi(dac_mosi), .cs_n(dac_cs_n)
  );

  // R8: no sample is taken while a frame is on the wire
  a_r8_busy_blocks_input: assert property (@(posedge clk) disable iff (rst)
    !dac_cs_n |-> !s_ready);
  // R1: idle serial clock stays low outside a frame
  a_r1_idle_sclk_low: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> !dac_sclk);
endmodule

// File: tb/tb_vol_dac_streamer.sv
module tb_vol_dac_streamer;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid = 1'b0;
  logic s_wide = 1'b0;
  logic [15:0] s_data = '0;
  logic [9:0] volume = '0;
  logic s_ready, dac_sclk, dac_mosi, dac_cs_n;

  int checks = 0;
  int fails = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  vol_dac_streamer #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_wide(s_wide), .s_data(s_data), .volume(volume),
    .dac_sclk(dac_sclk), .dac_mosi(dac_mosi), .dac_cs_n(dac_cs_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input bit wide, input logic [15:0] d,
                                        input int vol);
    int code;
    if (wide) code = int'((d ^ 16'h8000) >> 4);
    else      code = int'(d[7:0]) * 16;
    return 16'h3000 | 16'((code * vol) / 1024);
  endfunction

  // Driver: offers one sample, records the expected frame, waits for acceptance.
  task automatic send(input bit wide, input logic [15:0] d, input int vol,
                      input string tag, input int vol_after = -1);
    exp_q.push_back(model(wide, d, vol));
    tag_q.push_back(tag);
    @(negedge clk);
    s_valid = 1'b1; s_wide = wide; s_data = d; volume = 10'(vol);
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    s_data = 16'hDEAD;
    if (vol_after >= 0) volume = 10'(vol_after);
  endtask

  // Monitor: bit capture on rising serial clock, timing watch on falling system clock.
  logic [15:0] cap;
  int          nbits;
  bit          open_fr = 0;
  bit          bad_r6, bad_r8;
  int          hi_run, gap;
  int          period, last_rise;
  bit          bad_per;
  logic        p_sclk = 0, p_mosi = 0, p_cs = 1;
  int          cyc = 0;
  bit          seen_frame = 0;

  always @(posedge dac_sclk) if (!rst && !dac_cs_n) begin
    cap = {cap[14:0], dac_mosi};
    nbits++;
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (p_cs && !dac_cs_n) begin
        if (seen_frame) check(gap >= 2 * HALF, "R9 guard gap", gap, 2 * HALF);
        open_fr = 1; nbits = 0; cap = '0; bad_r6 = 0; bad_r8 = 0;
        bad_per = 0; last_rise = -1;
      end
      if (!dac_cs_n) begin
        if (p_sclk && dac_sclk && dac_mosi != p_mosi) bad_r6 = 1;
        if (s_ready) bad_r8 = 1;
        if (!p_sclk && dac_sclk) begin
          if (last_rise >= 0 && cyc - last_rise != 2 * HALF) bad_per = 1;
          last_rise = cyc;
        end
        gap = 0;
      end else begin
        gap++;
      end
      if (!p_cs && dac_cs_n && open_fr) begin
        logic [15:0] e;
        string t;
        open_fr = 0;
        seen_frame = 1;
        check(nbits == 16, "R7 sixteen clocks", nbits, 16);
        check(!bad_r6, "R6 mosi stable while sclk high", bad_r6, 0);
        check(!bad_per, "R6 sclk period", bad_per, 0);
        check(!bad_r8, "R8 ready low during frame", bad_r8, 0);
        if (exp_q.size() == 0) begin
          check(0, "R5 unexpected frame", cap, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(cap == e, {t, " frame word"}, cap, e);
          check(cap[15:12] == 4'b0011, "R5 command nibble", cap[15:12], 3);
        end
      end
    end
    p_sclk = dac_sclk; p_mosi = dac_mosi; p_cs = dac_cs_n;
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    join_none
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(s_ready == 1'b1, "R1 ready after reset", s_ready, 1);
    check(dac_cs_n == 1'b1, "R1 cs_n after reset", dac_cs_n, 1);
    check(dac_sclk == 1'b0, "R1 sclk after reset", dac_sclk, 0);

    send(1, 16'h7FFF, 1023, "R4 full scale");
    send(1, 16'h8000, 1023, "R2 most negative");
    send(1, 16'h1234, 1023, "R2 positive value");
    send(1, 16'h0000, 1023, "R2 midscale");
    send(0, 16'hA580, 512, "R3 narrow half volume");
    send(0, 16'h00FF, 1023, "R3 narrow top byte clear");
    send(0, 16'hFFFF, 1023, "R3 upper byte ignored");
    send(1, 16'h7FFF, 0, "R4 zero volume");
    send(1, 16'h7FFF, 1023, "R10 volume changed mid-frame", 0);
    send(1, 16'hC3A5, 700, "R4 partial volume");

    while (exp_q.size() != 0 || open_fr) @(negedge clk);
    repeat (4 * HALF + 4) @(negedge clk);
    check(s_ready == 1'b1, "R8 ready back after gap", s_ready, 1);
    check(dac_cs_n == 1'b1, "R7 cs_n idle high", dac_cs_n, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule